// File: doc/BRIEF.md
# Link Speed Validation Sequencer

This block runs on the initiator side of a parallel storage link. It proves that a transfer speed works before any user data is let through. After a start pulse it takes the negotiated speed index as its first candidate. At that speed it asks a bus engine for a buffer write carrying a generated test pattern, then for a readback of the same buffer. Each returned word is compared against a regenerated copy of the pattern.

A returned word that differs, a wrong word count, a parity or CRC error flag, or a command that never completes marks the candidate as bad. The sequencer then lowers the index by one and repeats the whole write/readback test. It settles on the first speed that passes. When the slowest index also fails, it parks in a fatal state. User traffic stays gated off in every state except the passing one.

The bus engine itself is outside this block. The sequencer drives a level request with an operation flag, streams the write pattern with a valid/ready pair, and accepts readback words on a valid strobe. The engine ends each command with a one-cycle done pulse.

Top module: `lsv_sequencer`

## Requirements
- R1: After reset the state output reads 0 (IDLE), and `user_en`, `fatal_err`, `cmd_req`, `wr_valid` and `sel_speed` are all 0.
- R2: A start pulse seen in IDLE (0), PASS (5) or FAIL (6) loads the candidate speed and enters WRITE (1) on the next edge. The candidate is the negotiated index, limited to NUM_SPEEDS-1 (4 by default). A start pulse in any other state changes nothing.
- R3: In WRITE, `cmd_req`=1 and `cmd_wr`=1, and `wr_valid` stays high until PAT_LEN words have been accepted on `wr_valid && wr_ready`. Word 0 is the seed 0xACE1. Each following word is (x>>1)^0xB400 when bit 0 of x is 1, and x>>1 otherwise.
- R4: A done pulse in WRITE after all PAT_LEN words were accepted moves to READ_CMP (2), with `cmd_req`=1 and `cmd_wr`=0. The pattern restarts from the seed, and each word strobed on `rd_valid` is compared in order.
- R5: A candidate fails on any of: a readback mismatch; a readback word beyond PAT_LEN; fewer than PAT_LEN words when done arrives, in either phase; `parity_err` or `crc_err` high in any WRITE or READ_CMP cycle.
- R6: A phase with no done pulse up to and including its phase-cycle index TMO_CYCLES (counted from 0 on entry) fails and leaves for EVAL.
- R7: The cycle after a phase ends, the state is EVAL (3). On a clean candidate the next state is PASS, and `sel_speed` holds the proven index.
- R8: A failed candidate above index 0 spends one cycle in STEP_DOWN (4), then re-enters WRITE with the index lowered by one.
- R9: A failed candidate at index 0 leads to FAIL with `fatal_err`=1.
- R10: `user_en` is 1 only in PASS and rises only straight after EVAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start or restart validation |
| neg_speed | input | SPD_W | Negotiated speed index |
| cmd_req | output | 1 | Command request to the bus engine |
| cmd_wr | output | 1 | 1 = buffer write, 0 = buffer read |
| cmd_done | input | 1 | One-cycle completion pulse from the bus engine |
| wr_valid | output | 1 | Test word offered |
| wr_ready | input | 1 | Bus engine takes the offered word |
| wr_data | output | WORD_W | Test pattern word |
| rd_valid | input | 1 | Readback word strobe |
| rd_data | input | WORD_W | Readback word |
| parity_err | input | 1 | Parity error flag from the bus |
| crc_err | input | 1 | CRC error flag from the bus |
| sel_speed | output | SPD_W | Candidate or proven speed index |
| user_en | output | 1 | User data transfer allowed |
| fatal_err | output | 1 | No speed passed |
| state | output | 3 | Sequencer state code |

## Verification
Every output is decoded from registers, so any input sampled at a rising edge shows its effect right after that edge. The bench drives and compares at falling edges, half a period from either side. A done pulse or timeout seen at edge n puts EVAL on the outputs after edge n. The verdict (PASS, STEP_DOWN or FAIL) appears after edge n+1, and a stepped-down WRITE after edge n+2. A behavioural model advances on the same rising edges from the same inputs and is compared with every output on each falling edge. Scenario checks then confirm the final speed and flags once PASS or FAIL is reached.

// File: rtl/lsv_pkg.sv
package lsv_pkg;

   typedef enum logic [2:0] {
      LSV_IDLE  = 3'd0,
      LSV_WRITE = 3'd1,
      LSV_RDCMP = 3'd2,
      LSV_EVAL  = 3'd3,
      LSV_STEP  = 3'd4,
      LSV_PASS  = 3'd5,
      LSV_FAIL  = 3'd6
   } lsv_state_e;

endpackage

// File: rtl/lsv_lfsr.sv
module lsv_lfsr #(
   parameter int          WORD_W = 16,
   parameter logic [15:0] SEED   = 16'hACE1,
   parameter logic [15:0] TAPS   = 16'hB400,
   parameter bit          GALOIS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   output logic [WORD_W-1:0] q
);

   localparam logic [WORD_W-1:0] SEED_W = WORD_W'(SEED);
   localparam logic [WORD_W-1:0] TAPS_W = WORD_W'(TAPS);

   if (WORD_W < 2) begin : g_bad_width
      $error("lsv_lfsr: WORD_W must be at least 2");
   end
   if (SEED_W == '0) begin : g_bad_seed
      $error("lsv_lfsr: seed must be nonzero");
   end

   logic [WORD_W-1:0] nxt;

   if (GALOIS) begin : g_galois
      assign nxt = q[0] ? ((q >> 1) ^ TAPS_W) : (q >> 1);
   end else begin : g_fibonacci
      logic fb;
      assign fb  = ^(q & TAPS_W);
      assign nxt = {q[WORD_W-2:0], fb};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= SEED_W;
      else if (load) q <= SEED_W;
      else if (adv)  q <= nxt;
   end

   // R3: pattern register never collapses to the all-zero lock-up value
   a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);

   // R4: a reload always brings back the seed
   a_r4_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == SEED_W);

endmodule

// File: rtl/lsv_timer.sv
module lsv_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expire
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lsv_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clr)                    cnt_q <= '0;
      else if (run && cnt_q != LIM_C)  cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && (cnt_q == LIM_C);

   // R6: expiry only after the timer has been running
   a_r6_expire_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(run));

endmodule

// File: rtl/lsv_word_track.sv
module lsv_word_track #(
   parameter int LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ev,
   output logic full,
   output logic will_full,
   output logic extra
);

   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LEN_C  = CW'(LEN);
   localparam logic [CW-1:0] LAST_C = CW'(LEN - 1);

   if (LEN < 1) begin : g_bad_len
      $error("lsv_word_track: LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr)                cnt_q <= '0;
      else if (ev && !full)        cnt_q <= cnt_q + 1'b1;
   end

   assign full      = (cnt_q == LEN_C);
   assign will_full = full || (ev && cnt_q == LAST_C);
   assign extra     = ev && full;

   // R5: the word count saturates at the pattern length
   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LEN_C);

endmodule

// File: rtl/lsv_sequencer.sv
module lsv_sequencer #(
   parameter int          NUM_SPEEDS = 5,
   parameter int          WORD_W     = 16,
   parameter int          PAT_LEN    = 8,
   parameter int          TMO_CYCLES = 64,
   parameter logic [15:0] SEED       = 16'hACE1,
   parameter logic [15:0] TAPS       = 16'hB400,
   parameter bit          GALOIS     = 1'b1,
   localparam int         SPD_W      = $clog2(NUM_SPEEDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SPD_W-1:0]  neg_speed,
   output logic              cmd_req,
   output logic              cmd_wr,
   input  logic              cmd_done,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [WORD_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [WORD_W-1:0] rd_data,
   input  logic              parity_err,
   input  logic              crc_err,
   output logic [SPD_W-1:0]  sel_speed,
   output logic              user_en,
   output logic              fatal_err,
   output logic [2:0]        state
);
   import lsv_pkg::*;

   localparam logic [SPD_W-1:0] MAX_IDX = SPD_W'(NUM_SPEEDS - 1);

   if (NUM_SPEEDS < 2) begin : g_bad_speeds
      $error("lsv_sequencer: at least two speeds are required");
   end

   lsv_state_e       state_q, state_d;
   logic [SPD_W-1:0] spd_q, spd_d;
   logic             fail_q, fail_d;

   logic in_write, in_read, in_phase, idle_like;
   logic hs, rd_ev, ev, start_ok, go_read, clr;
   logic full, will_full, extra, expire, bad_now;
   logic [WORD_W-1:0] pat;

   assign in_write  = (state_q == LSV_WRITE);
   assign in_read   = (state_q == LSV_RDCMP);
   assign in_phase  = in_write || in_read;
   assign idle_like = (state_q == LSV_IDLE) || (state_q == LSV_PASS) ||
                      (state_q == LSV_FAIL);

   assign hs       = in_write && wr_valid && wr_ready;
   assign rd_ev    = in_read && rd_valid;
   assign ev       = hs || rd_ev;
   assign start_ok = start && idle_like;
   assign go_read  = in_write && cmd_done && will_full;
   assign clr      = start_ok || go_read || (state_q == LSV_STEP);

   lsv_lfsr #(
      .WORD_W (WORD_W),
      .SEED   (SEED),
      .TAPS   (TAPS),
      .GALOIS (GALOIS)
   ) u_pat (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (clr),
      .adv   (ev),
      .q     (pat)
   );

   lsv_word_track #(.LEN(PAT_LEN)) u_words (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .ev        (ev),
      .full      (full),
      .will_full (will_full),
      .extra     (extra)
   );

   lsv_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .run    (in_phase),
      .expire (expire)
   );

   always_comb begin
      bad_now = 1'b0;
      if (in_phase && (parity_err || crc_err))   bad_now = 1'b1;
      if (rd_ev && (extra || rd_data != pat))    bad_now = 1'b1;
      if (in_phase && cmd_done && !will_full)    bad_now = 1'b1;
      if (in_phase && !cmd_done && expire)       bad_now = 1'b1;
   end

   always_comb begin
      state_d = state_q;
      spd_d   = spd_q;
      fail_d  = fail_q | bad_now;
      unique case (state_q)
         LSV_IDLE, LSV_PASS, LSV_FAIL: begin
            if (start) begin
               state_d = LSV_WRITE;
               spd_d   = (neg_speed > MAX_IDX) ? MAX_IDX : neg_speed;
               fail_d  = 1'b0;
            end
         end
         LSV_WRITE: begin
            if (cmd_done)      state_d = will_full ? LSV_RDCMP : LSV_EVAL;
            else if (expire)   state_d = LSV_EVAL;
         end
         LSV_RDCMP: begin
            if (cmd_done || expire) state_d = LSV_EVAL;
         end
         LSV_EVAL: begin
            if (!fail_q)            state_d = LSV_PASS;
            else if (spd_q == '0)   state_d = LSV_FAIL;
            else                    state_d = LSV_STEP;
         end
         LSV_STEP: begin
            state_d = LSV_WRITE;
            spd_d   = spd_q - 1'b1;
            fail_d  = 1'b0;
         end
         default: state_d = LSV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LSV_IDLE;
         spd_q   <= '0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         spd_q   <= spd_d;
         fail_q  <= fail_d;
      end
   end

   assign cmd_req   = in_phase;
   assign cmd_wr    = in_write;
   assign wr_valid  = in_write && !full;
   assign wr_data   = pat;
   assign sel_speed = spd_q;
   assign user_en   = (state_q == LSV_PASS);
   assign fatal_err = (state_q == LSV_FAIL);
   assign state     = state_q;

   // R8: step-down lowers the index by one and re-runs the write
   a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == LSV_STEP |=> state_q == LSV_WRITE && spd_q == $past(spd_q) - 1'b1);

   // R9: the fatal flag only rises with the slowest index selected
   a_r9_fatal_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fatal_err) |-> spd_q == '0);

   // R10: user traffic opens only straight after an evaluation
   a_r10_user_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_en) |-> $past(state_q) == LSV_EVAL);

   // R2: start pulses during a test leave the candidate alone
   a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      in_phase && start |=> $stable(spd_q));

   // R4: readback is only ever entered from the write phase
   a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      in_read |-> ($past(state_q) == LSV_WRITE || $past(state_q) == LSV_RDCMP));

   // R5: a differing readback word marks the candidate bad
   a_r5_mismatch_marks: assert property (@(posedge clk) disable iff (!rst_n)
      in_read && rd_valid && rd_data != wr_data |=> fail_q);

endmodule

// File: tb/lsv_sequencer_test.sv
module lsv_sequencer_test;

   localparam int NS   = 5;
   localparam int W    = 16;
   localparam int LEN  = 8;
   localparam int TMO  = 64;
   localparam int SW   = $clog2(NS);
   localparam logic [15:0] SEED = 16'hACE1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [SW-1:0] neg_speed = '0;
   logic cmd_req, cmd_wr;
   logic cmd_done = 1'b0;
   logic wr_valid;
   logic wr_ready = 1'b0;
   logic [W-1:0] wr_data;
   logic rd_valid = 1'b0;
   logic [W-1:0] rd_data = '0;
   logic parity_err = 1'b0;
   logic crc_err = 1'b0;
   logic [SW-1:0] sel_speed;
   logic user_en, fatal_err;
   logic [2:0] state;

   always #2.5 clk = ~clk;

   lsv_sequencer #(
      .NUM_SPEEDS (NS), .WORD_W (W), .PAT_LEN (LEN), .TMO_CYCLES (TMO)
   ) uut (
      .clk (clk), .rst_n (rst_n), .start (start), .neg_speed (neg_speed),
      .cmd_req (cmd_req), .cmd_wr (cmd_wr), .cmd_done (cmd_done),
      .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .parity_err (parity_err), .crc_err (crc_err),
      .sel_speed (sel_speed), .user_en (user_en), .fatal_err (fatal_err),
      .state (state)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int fmode [0:7];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] x);
      return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
   endfunction

   // reference model
   int m_st = 0, m_spd = 0, m_cnt = 0, m_tmr = 0;
   bit m_fail = 0;
   logic [15:0] m_lfsr = SEED;

   task automatic m_enter_write();
      m_st = 1; m_cnt = 0; m_tmr = 0; m_lfsr = SEED;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_spd = 0; m_fail = 0; m_cnt = 0; m_tmr = 0; m_lfsr = SEED;
      end else begin
         case (m_st)
            0, 5, 6: if (start) begin
               m_spd = (int'(neg_speed) > NS - 1) ? NS - 1 : int'(neg_speed);
               m_fail = 0;
               m_enter_write();
            end
            1: begin
               if (parity_err || crc_err) m_fail = 1;
               if (m_cnt < LEN && wr_ready) begin m_lfsr = nxt(m_lfsr); m_cnt++; end
               if (cmd_done) begin
                  if (m_cnt < LEN) begin m_fail = 1; m_st = 3; end
                  else begin m_st = 2; m_cnt = 0; m_tmr = 0; m_lfsr = SEED; end
               end else if (m_tmr == TMO) begin m_fail = 1; m_st = 3; end
               else m_tmr++;
            end
            2: begin
               if (parity_err || crc_err) m_fail = 1;
               if (rd_valid) begin
                  if (m_cnt >= LEN) m_fail = 1;
                  else begin
                     if (rd_data != m_lfsr) m_fail = 1;
                     m_lfsr = nxt(m_lfsr); m_cnt++;
                  end
               end
               if (cmd_done) begin
                  if (m_cnt != LEN) m_fail = 1;
                  m_st = 3;
               end else if (m_tmr == TMO) begin m_fail = 1; m_st = 3; end
               else m_tmr++;
            end
            3: m_st = !m_fail ? 5 : (m_spd == 0 ? 6 : 4);
            4: begin m_spd--; m_fail = 0; m_enter_write(); end
            default: m_st = 0;
         endcase
      end
   end

   // bus engine state
   int phase = 0, wcnt = 0, wcyc = 0, ridx = 0, rcyc = 0;
   bit dsent = 0;
   logic [15:0] mem [$];

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         finish_run();
      end
      if (rst_n) begin
         bit ev_wv;
         ev_wv = (m_st == 1) && (m_cnt < LEN);
         chk(state == 3'(m_st), "R7 state", state, m_st);
         chk(sel_speed == SW'(m_spd), "R8 sel_speed", sel_speed, m_spd);
         chk(user_en == (m_st == 5), "R10 user_en", user_en, m_st == 5);
         chk(fatal_err == (m_st == 6), "R9 fatal_err", fatal_err, m_st == 6);
         chk(cmd_req == (m_st == 1 || m_st == 2), "R4 cmd_req", cmd_req, m_st == 1 || m_st == 2);
         chk(cmd_wr == (m_st == 1), "R4 cmd_wr", cmd_wr, m_st == 1);
         chk(wr_valid == ev_wv, "R3 wr_valid", wr_valid, ev_wv);
         if (ev_wv) chk(wr_data == m_lfsr, "R3 wr_data", wr_data, m_lfsr);
      end
      // bus engine drive
      cmd_done = 0; rd_valid = 0; parity_err = 0; crc_err = 0; wr_ready = 0;
      if (!cmd_req) begin
         phase = 0;
      end else if (cmd_wr) begin
         int md, lim;
         md = fmode[sel_speed];
         if (phase != 1) begin phase = 1; wcnt = 0; wcyc = 0; dsent = 0; mem.delete(); end
         lim = (md == 7) ? LEN - 2 : LEN;
         if (wcnt < lim) begin
            wr_ready = (wcyc % 3) != 2;
            if (wr_ready && wr_valid) begin mem.push_back(wr_data); wcnt++; end
         end else if (!dsent && md != 4) begin
            cmd_done = 1; dsent = 1;
         end
         if (md == 3 && wcyc == 1) crc_err = 1;
         wcyc++;
      end else begin
         int md, nsend;
         md = fmode[sel_speed];
         if (phase != 2) begin phase = 2; ridx = 0; rcyc = 0; dsent = 0; end
         nsend = (md == 5) ? LEN - 1 : (md == 8) ? LEN + 1 : LEN;
         if (ridx < nsend) begin
            if ((rcyc % 4) != 3) begin
               rd_valid = 1;
               rd_data = (ridx < mem.size()) ? mem[ridx] : 16'h1234;
               if (md == 1 && ridx == 3) rd_data = rd_data ^ 16'h0040;
               if (md == 2 && ridx == 0) parity_err = 1;
               ridx++;
            end
         end else if (!dsent && md != 6) begin
            cmd_done = 1; dsent = 1;
         end
         rcyc++;
      end
   end

   task automatic kick(input int neg);
      neg_speed = SW'(neg);
      start = 1;
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_end();
      while (!(state == 3'd5 || state == 3'd6)) @(negedge clk);
   endtask

   task automatic set_modes(input int m0, input int m1, input int m2, input int m3, input int m4);
      fmode[0] = m0; fmode[1] = m1; fmode[2] = m2; fmode[3] = m3; fmode[4] = m4;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) fmode[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(state == 3'd0, "R1 state", state, 0);
      chk(!user_en && !fatal_err && !cmd_req && !wr_valid, "R1 outputs",
          {user_en, fatal_err, cmd_req, wr_valid}, 0);
      chk(sel_speed == '0, "R1 sel_speed", sel_speed, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // clean run at top speed, with a start pulse mid-test (R2 ignored)
      set_modes(0, 0, 0, 0, 0);
      kick(4);
      @(negedge clk); @(negedge clk);
      neg_speed = SW'(1);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(state == 3'd1, "R2 busy start state", state, 1);
      chk(sel_speed == SW'(4), "R2 busy start speed", sel_speed, 4);
      wait_end();
      chk(state == 3'd5 && sel_speed == SW'(4), "R7 pass at 4", sel_speed, 4);
      chk(user_en, "R10 user_en in PASS", user_en, 1);

      // restart from PASS; mismatch at 3, parity at 2 (R5, R8)
      set_modes(0, 0, 2, 1, 0);
      kick(3);
      chk(user_en == 0, "R10 user_en off after restart", user_en, 0);
      wait_end();
      chk(state == 3'd5 && sel_speed == SW'(1), "R5 step past mismatch/parity", sel_speed, 1);

      // clamp of out-of-range index; crc at 4, short read at 3, extra word at 2
      set_modes(0, 0, 8, 5, 3);
      kick(7);
      chk(sel_speed == SW'(4), "R2 clamp to max", sel_speed, 4);
      wait_end();
      chk(state == 3'd5 && sel_speed == SW'(1), "R5 crc/short/extra", sel_speed, 1);

      // write hang at 4, read hang at 3, early write done at 2 (R6)
      set_modes(0, 0, 7, 6, 4);
      kick(4);
      wait_end();
      chk(state == 3'd5 && sel_speed == SW'(1), "R6 timeouts step down", sel_speed, 1);

      // every speed bad from 2 down (R9)
      set_modes(1, 2, 3, 0, 0);
      kick(2);
      wait_end();
      chk(state == 3'd6 && fatal_err, "R9 fatal state", state, 6);
      chk(sel_speed == '0 && !user_en, "R9 floor speed no traffic", sel_speed, 0);

      // restart from FAIL with a clean link at index 0
      set_modes(0, 0, 0, 0, 0);
      kick(0);
      wait_end();
      chk(state == 3'd5 && sel_speed == '0 && !fatal_err, "R2 restart from FAIL", state, 5);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule